// File: doc/BRIEF.md
# Backlight Pulse-Width Generator with Run Handshake

This block drives the backlight dimming pin of a display panel with a pulse-width modulated signal. An 8-bit compare level sets how much of each period the output is active. A 3-bit prescaler setting slows the counter by a power of two. A polarity input selects whether the active level is high or low. A level of 0xF0 is a common brightness, and a level of 0x00 keeps the panel dark.

Software starts and stops the generator with two one-cycle strobes, one to enable and one to disable. Neither strobe acts at once. Each takes effect at the next boundary between periods. The `pwm_running` status output changes only at that boundary, so a driver can poll it to learn when its request has really been applied. Compare level, polarity and prescaler are sampled into shadow registers at each period start, so changing them never produces a runt pulse.

Top module: `bl_pwm_top`

## Requirements
- R1: After a synchronous active-low reset, `pwm_running` is 0 and `pwm_out` sits at its inactive level.
- R2: After an enable strobe while stopped, `pwm_running` rises exactly 2^S clock cycles later, where S is the prescaler setting. That edge is the start of the first period.
- R3: With polarity 0, `pwm_out` is high for exactly C×2^S clocks of every 256×2^S-clock period, where C is the compare level. The active part comes first, while the period counter is below C.
- R4: With polarity 1, the output is inverted. It is low for C×2^S clocks of each period, and it rests high while stopped.
- R5: Compare level 0 gives no active cycle in a period. Level 255 gives 255×2^S active cycles.
- R6: A compare change made in the middle of a period does not affect that period. It applies from the next period on.
- R7: After a disable strobe while running, `pwm_running` stays 1 until the current period ends, then falls at the period boundary.
- R8: While `pwm_running` is 0, `pwm_out` equals `cfg_pol`, which is the inactive level.
- R9: An enable strobe while running does not restart or change the period. A disable strobe while stopped leaves the block stopped.
- R10: When enable and disable strobes arrive in the same cycle, disable takes priority.
- R11: An enable strobe given after a disable, but before the period boundary, cancels the stop, and the PWM keeps running.
- R12: The prescaler divides the counting clock by 2^S for every setting S from 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cmp | input | 8 | Compare level (duty) |
| cfg_pol | input | 1 | Output polarity, 1 = active low |
| cfg_psc | input | 3 | Prescaler setting S, divide by 2^S |
| en_stb | input | 1 | One-cycle enable request |
| dis_stb | input | 1 | One-cycle disable request |
| pwm_out | output | 1 | Backlight PWM output |
| pwm_running | output | 1 | Status: PWM running |

## Verification
The bench sweeps the prescaler setting from 0 to 6 at a fixed level. Both the start latency and the active count of a full period must scale by 2^S, which separates a wrong divider from a wrong duty comparison. At the fastest setting it tries levels 0, 1, 0x7F, 0xF0 and 0xFF under both polarities. These catch off-by-one errors at the comparison boundaries and inversion mistakes, both inside a period and at rest. Further tests cover:
- a compare change in mid-period, which tells shadowed updates apart from live ones;
- strobes placed in each state: redundant, simultaneous and cancelling. These show whether the state change waits for the period boundary and which request wins.

// File: rtl/bl_pwm_pkg.sv
// Shared types for the backlight PWM block.
package bl_pwm_pkg;

    // Control state of the start/stop handshake
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // stopped, output at inactive level
        ST_ARM   = 2'd1,   // enable accepted, waiting for first boundary
        ST_RUN   = 2'd2,   // generating periods
        ST_DRAIN = 2'd3    // disable accepted, finishing current period
    } bl_state_e;

endpackage

// File: rtl/bl_pwm_prescale.sv
// Prescaler: emits a one-cycle tick every 2^setting clocks while run is high.
// Assumes setting only changes while run is low or on a tick (held stable by
// the shadow register upstream). The counter restarts from zero when run rises.
module bl_pwm_prescale #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] setting,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_mask;

    // Terminal count mask: low 'setting' bits set
    for (genvar g = 0; g < DIV_W; g++) begin : g_mask
        assign div_mask[g] = (g < int'(setting));
    end

    assign tick = run && (div_cnt == div_mask);

    // Divider counter, cleared while stopped and on every tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!run || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bl_pwm_period.sv
// Period counter with shadowed configuration.
// Counts prescaled ticks modulo 2^CMP_W. While idle the counter rests at its
// maximum so that the first tick after an enable opens a fresh period.
// Compare, polarity and prescaler are loaded while idle and at each wrap only.
module bl_pwm_period #(
    parameter int CMP_W = 8,
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             tick,
    input  logic [CMP_W-1:0] cfg_cmp,
    input  logic             cfg_pol,
    input  logic [PSC_W-1:0] cfg_psc,
    output logic [CMP_W-1:0] cnt,
    output logic             wrap,
    output logic [CMP_W-1:0] cmp_sh,
    output logic             pol_sh,
    output logic [PSC_W-1:0] psc_sh
);
    localparam logic [CMP_W-1:0] CNT_MAX = '1;

    assign wrap = tick && (cnt == CNT_MAX);

    // Period position: parked at maximum while idle, advances on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_MAX;
        end else if (idle) begin
            cnt <= CNT_MAX;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Shadow configuration: follows inputs while idle, frozen inside a period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_sh <= '0;
            pol_sh <= 1'b0;
            psc_sh <= '0;
        end else if (idle || wrap) begin
            cmp_sh <= cfg_cmp;
            pol_sh <= cfg_pol;
            psc_sh <= cfg_psc;
        end
    end

endmodule

// File: rtl/bl_pwm_ctrl.sv
// Start/stop handshake. Requests are accepted at once but applied at the
// next period boundary (wrap). Disable has priority over enable.
// Assumes wrap is only asserted while the counters are active.
module bl_pwm_ctrl
    import bl_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_stb,
    input  logic dis_stb,
    input  logic wrap,
    output logic running,
    output logic active
);
    bl_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (!dis_stb && en_stb) state_d = ST_ARM;
            ST_ARM:   if (dis_stb) state_d = ST_OFF;
                      else if (wrap) state_d = ST_RUN;
            ST_RUN:   if (dis_stb) state_d = ST_DRAIN;
            ST_DRAIN: if (wrap) state_d = (!dis_stb && en_stb) ? ST_RUN : ST_OFF;
                      else if (!dis_stb && en_stb) state_d = ST_RUN;
            default:  state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    assign running = (state_q == ST_RUN) || (state_q == ST_DRAIN);
    assign active  = (state_q != ST_OFF);

endmodule

// File: rtl/bl_pwm_top.sv
// Backlight PWM top: prescaler, period counter with shadows, handshake FSM
// and output stage. The output is built from registered state only, apart
// from the live polarity used while stopped.
module bl_pwm_top #(
    parameter int CMP_W = 8,
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] cfg_cmp,
    input  logic             cfg_pol,
    input  logic [PSC_W-1:0] cfg_psc,
    input  logic             en_stb,
    input  logic             dis_stb,
    output logic             pwm_out,
    output logic             pwm_running
);
    logic             ctr_active;
    logic             tick;
    logic             wrap;
    logic [CMP_W-1:0] period_cnt;
    logic [CMP_W-1:0] cmp_shadow;
    logic             pol_shadow;
    logic [PSC_W-1:0] psc_shadow;
    logic             in_window;

    bl_pwm_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctr_active),
        .setting (psc_shadow),
        .tick    (tick)
    );

    bl_pwm_period #(.CMP_W(CMP_W), .PSC_W(PSC_W)) u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle    (!ctr_active),
        .tick    (tick),
        .cfg_cmp (cfg_cmp),
        .cfg_pol (cfg_pol),
        .cfg_psc (cfg_psc),
        .cnt     (period_cnt),
        .wrap    (wrap),
        .cmp_sh  (cmp_shadow),
        .pol_sh  (pol_shadow),
        .psc_sh  (psc_shadow)
    );

    bl_pwm_ctrl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_stb  (en_stb),
        .dis_stb (dis_stb),
        .wrap    (wrap),
        .running (pwm_running),
        .active  (ctr_active)
    );

    // Output stage: active while counter below compare, inactive when stopped
    assign in_window = (period_cnt < cmp_shadow);
    assign pwm_out   = pwm_running ? (in_window ^ pol_shadow) : cfg_pol;

endmodule

// File: rtl/bl_pwm_chk.sv
// Checker for bl_pwm_top, attached by bind.
module bl_pwm_chk #(
    parameter int CMP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_pol,
    input logic             en_stb,
    input logic             dis_stb,
    input logic             pwm_out,
    input logic             pwm_running,
    input logic [CMP_W-1:0] period_cnt,
    input logic [CMP_W-1:0] cmp_shadow,
    input logic             pol_shadow
);
    // R2: the run status rises only as a new period opens
    a_r2_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_running) |-> period_cnt == '0);

    // R7: the run status falls only at a period boundary
    a_r7_stop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_running) |-> period_cnt == '0);

    // R6: the compare shadow never moves inside a running period
    a_r6_cmp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_running && $past(pwm_running) && period_cnt != '0) |-> $stable(cmp_shadow));

    // R8: stopped output rests at the inactive level
    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_running |-> pwm_out == cfg_pol);

    // R10: simultaneous strobes while stopped never start the PWM
    a_r10_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (en_stb && dis_stb && !pwm_running) |=> !pwm_running);

    // R5: a zero level keeps the output inactive all period
    a_r5_zero_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_running && cmp_shadow == '0) |-> pwm_out == pol_shadow);

endmodule

bind bl_pwm_top bl_pwm_chk #(.CMP_W(CMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_pol     (cfg_pol),
    .en_stb      (en_stb),
    .dis_stb     (dis_stb),
    .pwm_out     (pwm_out),
    .pwm_running (pwm_running),
    .period_cnt  (period_cnt),
    .cmp_shadow  (cmp_shadow),
    .pol_shadow  (pol_shadow)
);

// File: tb/bl_pwm_top_tb.sv
module bl_pwm_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_cmp = 8'h00;
    logic       cfg_pol = 1'b0;
    logic [2:0] cfg_psc = 3'd0;
    logic       en_stb = 1'b0;
    logic       dis_stb = 1'b0;
    logic       pwm_out;
    logic       pwm_running;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bl_pwm_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_cmp     (cfg_cmp),
        .cfg_pol     (cfg_pol),
        .cfg_psc     (cfg_psc),
        .en_stb      (en_stb),
        .dis_stb     (dis_stb),
        .pwm_out     (pwm_out),
        .pwm_running (pwm_running)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load config while stopped, strobe enable, measure start latency (sample 0 on exit)
    task automatic start(input int p, input int cmp, input bit pol, output int lat);
        @(negedge clk);
        cfg_psc = 3'(p); cfg_cmp = 8'(cmp); cfg_pol = pol;
        en_stb = 1'b1;
        @(negedge clk);
        en_stb = 1'b0;
        lat = 0;
        while (!pwm_running && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Observe one full period from sample 0; strobes/config change at given indices
    task automatic run_period(input int p, input bit pol, input int dis_at, input int en_at,
                              input int chg_at, input int new_cmp,
                              output int act, output bit run_last, output bit run_end,
                              output bit out_end);
        int n;
        n = 256 << p;
        act = 0;
        run_last = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out !== pol) act++;
            if (i == n - 1) run_last = pwm_running;
            en_stb  = (i == en_at);
            dis_stb = (i == dis_at);
            if (i == chg_at) cfg_cmp = 8'(new_cmp);
            @(negedge clk);
            en_stb  = 1'b0;
            dis_stb = 1'b0;
        end
        run_end = pwm_running;
        out_end = pwm_out;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat, act;
        bit rl, re, oe;
        int lv [5];
        lv = '{0, 1, 8'h7F, 8'hF0, 8'hFF};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pwm_running == 1'b0, "R1 running after reset", pwm_running, 0);
        chk(pwm_out == 1'b0, "R1 output after reset", pwm_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_pol = 1'b1;
        #1;
        chk(pwm_out == 1'b1, "R8 idle level follows polarity", pwm_out, 1);
        cfg_pol = 1'b0;

        // R12 / R2 / R3 / R7: prescaler sweep at level 0x40
        for (int p = 0; p <= 6; p++) begin
            start(p, 8'h40, 1'b0, lat);
            chk(lat == (1 << p), $sformatf("R2 R12 start latency S=%0d", p), lat, 1 << p);
            run_period(p, 1'b0, (128 << p), -1, -1, 0, act, rl, re, oe);
            chk(act == (8'h40 << p), $sformatf("R3 R12 active count S=%0d", p), act, 8'h40 << p);
            chk(rl == 1'b1, $sformatf("R7 still running at last cycle S=%0d", p), rl, 1);
            chk(re == 1'b0, $sformatf("R7 stopped at boundary S=%0d", p), re, 0);
            chk(oe == 1'b0, $sformatf("R8 inactive after stop S=%0d", p), oe, 0);
        end

        // R3 R4 R5: level sweep at S=0, both polarities
        for (int pol = 0; pol < 2; pol++) begin
            for (int k = 0; k < 5; k++) begin
                start(0, lv[k], 1'(pol), lat);
                run_period(0, 1'(pol), 0, -1, -1, 0, act, rl, re, oe);
                chk(act == lv[k], $sformatf("R3 R4 R5 level=%0d pol=%0d", lv[k], pol), act, lv[k]);
                chk(oe == 1'(pol), $sformatf("R4 R8 rest level pol=%0d", pol), oe, pol);
            end
        end

        // R6: compare change mid-period applies next period
        start(1, 8'h20, 1'b0, lat);
        run_period(1, 1'b0, -1, -1, 10, 8'h90, act, rl, re, oe);
        chk(act == (8'h20 << 1), "R6 old level kept in current period", act, 8'h20 << 1);
        run_period(1, 1'b0, 5, -1, -1, 0, act, rl, re, oe);
        chk(act == (8'h90 << 1), "R6 new level in next period", act, 8'h90 << 1);
        chk(re == 1'b0, "R7 stop after R6 test", re, 0);

        // R9: enable while running ignored
        start(0, 8'h33, 1'b0, lat);
        run_period(0, 1'b0, -1, 3, -1, 0, act, rl, re, oe);
        chk(act == 8'h33, "R9 enable while running leaves period", act, 8'h33);
        chk(re == 1'b1, "R9 still running after redundant enable", re, 1);
        run_period(0, 1'b0, 7, -1, -1, 0, act, rl, re, oe);
        chk(re == 1'b0, "R9 stop after redundant enable", re, 0);

        // R9: disable while stopped ignored, then enable still works
        @(negedge clk);
        dis_stb = 1'b1;
        @(negedge clk);
        dis_stb = 1'b0;
        repeat (5) @(negedge clk);
        chk(pwm_running == 1'b0, "R9 disable while stopped", pwm_running, 0);
        chk(pwm_out == 1'b0, "R9 output stays inactive", pwm_out, 0);
        start(2, 8'h10, 1'b0, lat);
        chk(lat == 4, "R2 latency after ignored disable", lat, 4);
        run_period(2, 1'b0, 0, -1, -1, 0, act, rl, re, oe);
        chk(act == (8'h10 << 2), "R3 active count S=2", act, 8'h10 << 2);

        // R10: both strobes while stopped
        @(negedge clk);
        cfg_psc = 3'd0;
        en_stb = 1'b1; dis_stb = 1'b1;
        @(negedge clk);
        en_stb = 1'b0; dis_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk(pwm_running == 1'b0, "R10 both strobes while stopped", pwm_running, 0);

        // R10: both strobes while running
        start(0, 8'h80, 1'b0, lat);
        run_period(0, 1'b0, 20, 20, -1, 0, act, rl, re, oe);
        chk(re == 1'b0, "R10 both strobes while running stop", re, 0);

        // R11: enable after disable before boundary cancels stop
        start(0, 8'h50, 1'b0, lat);
        run_period(0, 1'b0, 10, 20, -1, 0, act, rl, re, oe);
        chk(re == 1'b1, "R11 stop cancelled", re, 1);
        chk(act == 8'h50, "R11 period unaffected", act, 8'h50);
        run_period(0, 1'b0, 0, -1, -1, 0, act, rl, re, oe);
        chk(act == 8'h50, "R11 next period count", act, 8'h50);
        chk(re == 1'b0, "R11 final stop", re, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule